// File: doc/BRIEF.md
# Stochastically Rounded 8-bit × 8-bit → 12-bit Floating-Point Multiply-Accumulate

This block multiplies two 8-bit floating-point operands and adds the product into a 12-bit floating-point accumulator register. It is meant for the inner loop of neural-network training, where long chains of small products would otherwise be lost against a large running sum. The product is formed exactly. The only rounding step is in the addition, and it is stochastic: a random word supplied each cycle is added just below the last kept significand bit, and the sum is then truncated.

To keep the adder short, the random word is injected early, at the position predicted from the larger addend, before the true leading one of the sum is known. A late correction step then repairs the two cases where the prediction is wrong: a carry out of the top bit, and a loss of leading bits through cancellation. Values below the smallest normal number are treated as zero. Overflow saturates to the largest finite magnitude.

Operands are presented with a valid strobe. A separate load strobe writes an initial value into the accumulator, and the load takes precedence over a multiply-accumulate in the same cycle.

Top module: `sr_mac_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, accOut reads 12'h000.
- R2: When initEn is high at a clock edge, accOut takes initVal after that edge, whatever opValid, opA, opB and rndBits hold.
- R3: When initEn and opValid are both low at a clock edge, accOut does not change, whatever opA, opB and rndBits hold.
- R4: When opValid is high and initEn low, accOut becomes the stochastically rounded value of acc + a·b. Formats: input = {sign[7], exp[6:3] bias 7, frac[2:0]}; accumulator = {sign[11], exp[10:6] bias 15, frac[5:0]}; every exponent code 1..31 is finite. In units of 2^-20, with S the exact sum, m the index of its leading one and R = rndBits, the result significand is floor((|S|·2^N + R·2^(m-6)) / 2^(m-6+N)) with N = RAND_W, the biased exponent is m-5, and the sign is that of S. The product is never rounded on its own.
- R5: When the sum has its leading one one place above that of the larger addend (carry case), the random word counts with weight 2^(m-6) for the new m, not at the position predicted from the larger addend.
- R6: When cancellation places the sum's leading one below that of the larger addend, the random word is aligned to the sum's actual leading one.
- R7: A sum that is exactly representable in the accumulator format is returned unchanged for every random word.
- R8: An operand or accumulator value with exponent code 0 counts as zero whatever its fraction holds. A nonzero exact sum with magnitude below 2^-14 gives 12'h000. A multiply-accumulate never leaves a nonzero pattern with exponent code 0.
- R9: An exact zero sum gives +0 (12'h000), never 12'h800.
- R10: When the biased exponent after rounding exceeds 31, the result is the largest finite magnitude with the sum's sign: 12'h7FF or 12'hFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| initEn | input | 1 | Load initVal into the accumulator (takes priority) |
| initVal | input | 12 | Value loaded into the accumulator |
| opValid | input | 1 | Operand pair valid: perform a multiply-accumulate |
| opA | input | 8 | First 8-bit floating-point multiplicand |
| opB | input | 8 | Second 8-bit floating-point multiplicand |
| rndBits | input | RAND_W | Random word for stochastic rounding |
| accOut | output | 12 | Accumulator contents |

## Verification
The bench builds the block with RAND_W = 3, so every one of the eight random words can be applied to each operand triple. At that width, all 256 first operands are swept against twelve second operands and two accumulator styles: one random, and one sign-opposed and close to the product, which pushes many cases into cancellation. Directed triples pin down the carry-correction and cancellation-correction cases, where a random word at the wrong weight changes the result. Further triples cover saturation, underflow to zero and exact cancellation.

// File: rtl/sr_mac_pkg.sv
package sr_mac_pkg;
  // 8-bit input format
  localparam int IN_EXP_W   = 4;
  localparam int IN_FRAC_W  = 3;
  // 12-bit accumulator format
  localparam int ACC_EXP_W  = 5;
  localparam int ACC_FRAC_W = 6;
  localparam int ACC_W      = 1 + ACC_EXP_W + ACC_FRAC_W;

  localparam int IN_SIG_W   = IN_FRAC_W + 1;
  localparam int PROD_W     = 2 * IN_SIG_W;
  localparam int KEEP_W     = ACC_FRAC_W + 1;
  // Fixed-point frame: lsb = smallest accumulator ulp; positions of operand lsbs
  localparam int PROD_SHIFT_MAX = 2 * ((1 << IN_EXP_W) - 1);
  localparam int ACC_SHIFT_MAX  = (1 << ACC_EXP_W) - 2;
  localparam int MAG_TOP  = (KEEP_W + ACC_SHIFT_MAX > PROD_W + PROD_SHIFT_MAX) ?
                            KEEP_W + ACC_SHIFT_MAX : PROD_W + PROD_SHIFT_MAX;
  localparam int MAG_W    = MAG_TOP + 1;
  localparam int MSB_W    = $clog2(MAG_W);
  localparam int EXP_OFF  = ACC_FRAC_W - 1;
  localparam int EXP_MAX  = (1 << ACC_EXP_W) - 1;

  typedef struct packed {
    logic                  sign;
    logic [IN_EXP_W-1:0]   exp;
    logic [IN_FRAC_W-1:0]  frac;
  } in_fp_t;

  typedef struct packed {
    logic                  sign;
    logic [ACC_EXP_W-1:0]  exp;
    logic [ACC_FRAC_W-1:0] frac;
  } acc_fp_t;

  typedef struct packed {
    logic loadInit;
    logic accumulate;
  } mac_strobe_t;

  function automatic logic [MSB_W-1:0] leadOne(input logic [MAG_W-1:0] v);
    logic [MSB_W-1:0] r;
    r = '0;
    for (int i = 0; i < MAG_W; i++) begin
      if (v[i]) r = MSB_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/sr_mac_ctrl.sv
module sr_mac_ctrl
  import sr_mac_pkg::*;
(
  input  logic        initEn,
  input  logic        opValid,
  output mac_strobe_t strobe
);
  always_comb begin
    strobe.loadInit   = initEn;
    strobe.accumulate = opValid && !initEn;
  end
endmodule

// File: rtl/sr_mac_round.sv
module sr_mac_round
  import sr_mac_pkg::*;
#(
  parameter int RAND_W = 8
) (
  input  logic [MAG_W-1:0]  sumMag,
  input  logic [MSB_W-1:0]  msbBig,
  input  logic [MSB_W-1:0]  msbSum,
  input  logic              sumSign,
  input  logic [RAND_W-1:0] rnd,
  output acc_fp_t           result
);
  localparam int SW = MAG_W + RAND_W + 1;

  logic [SW-1:0]    sScaled, rndEager, eagerSum, fixedSum;
  logic [MSB_W-1:0] eagerPos, latePos;
  logic [KEEP_W:0]  winBits;
  logic [MSB_W:0]   expWide;
  logic             carryCase, cancelCase, roundOvf, tooSmall, saturate;

  always_comb begin
    eagerPos = (msbBig >= MSB_W'(KEEP_W - 1)) ? msbBig - MSB_W'(KEEP_W - 1) : '0;
    latePos  = (msbSum >= MSB_W'(KEEP_W - 1)) ? msbSum - MSB_W'(KEEP_W - 1) : '0;
    sScaled  = SW'(sumMag) << RAND_W;
    // eager injection: random word placed below the larger addend's kept bits
    rndEager = SW'(rnd) << eagerPos;
    eagerSum = sScaled + rndEager;
    carryCase  = msbSum > msbBig;
    cancelCase = msbSum < msbBig;
    // late correction, one rule per normalisation case
    if (carryCase)       fixedSum = eagerSum + rndEager;
    else if (cancelCase) fixedSum = sScaled + (SW'(rnd) << latePos);
    else                 fixedSum = eagerSum;
    winBits  = (KEEP_W + 1)'(fixedSum >> (int'(latePos) + RAND_W));
    roundOvf = winBits[KEEP_W];
    tooSmall = (sumMag == '0) || (msbSum < MSB_W'(KEEP_W - 1))
               || !(winBits[KEEP_W] || winBits[KEEP_W-1]);
    expWide  = {1'b0, msbSum} - (MSB_W + 1)'(EXP_OFF) + {{MSB_W{1'b0}}, roundOvf};
    saturate = expWide > (MSB_W + 1)'(EXP_MAX);
    if (tooSmall) begin
      result = '0;
    end else if (saturate) begin
      result.sign = sumSign;
      result.exp  = '1;
      result.frac = '1;
    end else begin
      result.sign = sumSign;
      result.exp  = expWide[ACC_EXP_W-1:0];
      result.frac = winBits[ACC_FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/sr_mac_dp.sv
module sr_mac_dp
  import sr_mac_pkg::*;
#(
  parameter int RAND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mac_strobe_t       strobe,
  input  logic [ACC_W-1:0]  initVal,
  input  logic [7:0]        opA,
  input  logic [7:0]        opB,
  input  logic [RAND_W-1:0] rndBits,
  output logic [ACC_W-1:0]  accOut
);
  in_fp_t           inA, inB;
  acc_fp_t          accQ, accNext;
  logic             prodZero, accZero, prodSign, accBig, effSub, bigSign;
  logic [PROD_W-1:0] prodSig;
  logic [MAG_W-1:0] prodMag, accMag, bigMag, smallMag, sumMag;
  logic [MSB_W-1:0] msbBig, msbSum;

  always_comb begin
    inA = in_fp_t'(opA);
    inB = in_fp_t'(opB);
    prodZero = (inA.exp == '0) || (inB.exp == '0);
    accZero  = (accQ.exp == '0);
    prodSig  = PROD_W'({1'b1, inA.frac}) * PROD_W'({1'b1, inB.frac});
    prodSign = inA.sign ^ inB.sign;
    prodMag  = prodZero ? '0 : MAG_W'(prodSig) << (int'(inA.exp) + int'(inB.exp));
    accMag   = accZero ? '0 : MAG_W'({1'b1, accQ.frac}) << (int'(accQ.exp) - 1);
    accBig   = accMag >= prodMag;
    bigMag   = accBig ? accMag : prodMag;
    smallMag = accBig ? prodMag : accMag;
    bigSign  = accBig ? accQ.sign : prodSign;
    effSub   = (accQ.sign != prodSign) && !accZero && !prodZero;
    sumMag   = effSub ? bigMag - smallMag : bigMag + smallMag;
    msbBig   = leadOne(bigMag);
    msbSum   = leadOne(sumMag);
  end

  sr_mac_round #(.RAND_W(RAND_W)) round_i (
    .sumMag (sumMag),
    .msbBig (msbBig),
    .msbSum (msbSum),
    .sumSign(bigSign),
    .rnd    (rndBits),
    .result (accNext)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 accQ <= '0;
    else if (strobe.loadInit)   accQ <= acc_fp_t'(initVal);
    else if (strobe.accumulate) accQ <= accNext;
  end

  assign accOut = accQ;
endmodule

// File: rtl/sr_mac_top.sv
module sr_mac_top
  import sr_mac_pkg::*;
#(
  parameter int RAND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              initEn,
  input  logic [11:0]       initVal,
  input  logic              opValid,
  input  logic [7:0]        opA,
  input  logic [7:0]        opB,
  input  logic [RAND_W-1:0] rndBits,
  output logic [11:0]       accOut
);
  mac_strobe_t strobe;

  sr_mac_ctrl ctrl_i (
    .initEn (initEn),
    .opValid(opValid),
    .strobe (strobe)
  );

  sr_mac_dp #(.RAND_W(RAND_W)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .initVal(initVal),
    .opA    (opA),
    .opB    (opB),
    .rndBits(rndBits),
    .accOut (accOut)
  );
endmodule

// File: rtl/sr_mac_checker.sv
module sr_mac_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        initEn,
  input logic [11:0] initVal,
  input logic        opValid,
  input logic [11:0] accOut
);
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> accOut == 12'h000);

  assert_init_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    initEn |=> accOut == $past(initVal));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!initEn && !opValid) |=> $stable(accOut));

  assert_no_subnormal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !initEn) |=> (accOut[10:6] != 5'd0 || accOut == 12'h000));

  assert_no_neg_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !initEn) |=> accOut != 12'h800);
endmodule

bind sr_mac_top sr_mac_checker chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .initEn (initEn),
  .initVal(initVal),
  .opValid(opValid),
  .accOut (accOut)
);

// File: tb/sr_mac_top_tb_top.sv
module sr_mac_top_tb_top;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          initEn = 1'b0;
  logic [11:0]   initVal = '0;
  logic          opValid = 1'b0;
  logic [7:0]    opA = '0;
  logic [7:0]    opB = '0;
  logic [RW-1:0] rndBits = '0;
  logic [11:0]   accOut;

  int compared = 0;
  int mismatched = 0;
  bit [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  sr_mac_top #(.RAND_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .initEn(initEn), .initVal(initVal),
    .opValid(opValid), .opA(opA), .opB(opB), .rndBits(rndBits), .accOut(accOut)
  );

  function automatic bit [31:0] nextRand(bit [31:0] s);
    bit [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic int msbOf(longint v);
    int r = -1;
    for (int i = 0; i < 62; i++) if (v[i]) r = i;
    return r;
  endfunction

  // Arithmetic reference: exact sum, random word at the truncation point, truncate.
  function automatic logic [11:0] refMac(logic [11:0] acc, logic [7:0] a, logic [7:0] b,
                                         int r, output string tag);
    longint accV, pV, s, mag, q;
    int m, mb, e;
    bit sgn;
    accV = (acc[10:6] == 0) ? 0 : longint'(64 + acc[5:0]) <<< (int'(acc[10:6]) - 1);
    if (acc[11]) accV = -accV;
    pV = (a[6:3] == 0 || b[6:3] == 0) ? 0 :
         (longint'(8 + a[2:0]) * longint'(8 + b[2:0])) <<< (int'(a[6:3]) + int'(b[6:3]));
    if (a[7] ^ b[7]) pV = -pV;
    s = accV + pV;
    mb = msbOf((accV < 0 ? -accV : accV) > (pV < 0 ? -pV : pV) ?
               (accV < 0 ? -accV : accV) : (pV < 0 ? -pV : pV));
    if (s == 0) begin tag = "R9"; return 12'h000; end
    sgn = s < 0;
    mag = sgn ? -s : s;
    m = msbOf(mag);
    if (m < 6) begin tag = "R8"; return 12'h000; end
    q = ((mag <<< RW) + (longint'(r) <<< (m - 6))) >>> (m - 6 + RW);
    e = m - 5;
    if (q >= 128) begin q = 64; e = e + 1; end
    if (e > 31) begin tag = "R10"; return {sgn, 11'h7FF}; end
    tag = (m > mb) ? "R5" : (m < mb) ? "R6" : "R4";
    return {sgn, 5'(e), 6'(q - 64)};
  endfunction

  task automatic check(string req, logic [11:0] exp);
    compared++;
    if (accOut !== exp) begin
      mismatched++;
      $display("FAIL %s: accOut=%h expected=%h", req, accOut, exp);
    end
  endtask

  // Load acc, run one MAC, compare one cycle later (sampled on negedge).
  task automatic runCase(logic [11:0] acc, logic [7:0] a, logic [7:0] b, int r,
                         string forceTag);
    string tag;
    logic [11:0] exp;
    @(negedge clk);
    initEn = 1'b1; initVal = acc; opValid = 1'b0;
    @(negedge clk);
    initEn = 1'b0; opValid = 1'b1; opA = a; opB = b; rndBits = RW'(r);
    @(negedge clk);
    opValid = 1'b0;
    exp = refMac(acc, a, b, r, tag);
    check(forceTag == "" ? tag : forceTag, exp);
  endtask

  initial begin
    #1_900_000;
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [11:0] held, accModel;
    string tag;
    repeat (3) @(negedge clk);
    check("R1", 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 12'h000);

    // R2: load wins over a simultaneous MAC
    initEn = 1'b1; initVal = 12'h5A3; opValid = 1'b1; opA = 8'h38; opB = 8'h38;
    @(negedge clk);
    initEn = 1'b0; opValid = 1'b0;
    check("R2", 12'h5A3);

    // R3: idle cycles ignore operand and random changes
    held = accOut;
    for (int k = 0; k < 4; k++) begin
      opA = 8'(k * 37 + 1); opB = 8'(k * 91 + 3); rndBits = RW'(k);
      @(negedge clk);
      check("R3", held);
    end

    // R5 carry case: 1.984375 + 1.0
    for (int r = 0; r < 8; r++) runCase(12'h3FF, 8'h38, 8'h38, r, "R5");
    for (int r = 0; r < 8; r++) begin
      runCase(12'h3FF, 8'h38, 8'h38, r, "");
    end
    // R6 cancellation: 1.0 - small, only lazy alignment gives 0x3BC for every r
    for (int r = 0; r < 8; r++) begin
      runCase(12'hA7F, 8'h38, 8'h38, r, "R6");
      check("R6", 12'h3BC);
    end
    // R7 exactly representable: 1.0 + 1.0 = 2.0
    for (int r = 0; r < 8; r++) begin
      runCase(12'h3C0, 8'h38, 8'h38, r, "R7");
      check("R7", 12'h400);
    end
    // R8 subnormal operand pattern counts as zero; R8 underflow flushes
    for (int r = 0; r < 8; r++) begin
      runCase(12'h5A3, 8'h38, 8'h05, r, "R8");
      check("R8", 12'h5A3);
    end
    runCase(12'h015, 8'h38, 8'h38, 5, "R8");
    check("R8", 12'h3C0);
    runCase(12'h8BF, 8'h08, 8'h08, 7, "R8");
    check("R8", 12'h000);
    // R9 exact cancellation gives +0
    for (int r = 0; r < 8; r++) begin
      runCase(12'hBC0, 8'h38, 8'h38, r, "R9");
      check("R9", 12'h000);
    end
    // R10 saturation, both signs
    runCase(12'h7FF, 8'h7F, 8'h7F, 7, "R10");
    check("R10", 12'h7FF);
    runCase(12'hFFF, 8'hFF, 8'h7F, 0, "R10");
    check("R10", 12'hFFF);

    // R4 running accumulation chain without reloads
    @(negedge clk);
    initEn = 1'b1; initVal = 12'h3C0;
    @(negedge clk);
    initEn = 1'b0;
    accModel = 12'h3C0;
    for (int k = 0; k < 60; k++) begin
      seed = nextRand(seed);
      opA = 8'(seed[7:0] | 8'h18); opB = 8'(seed[15:8] & 8'hBF | 8'h20);
      rndBits = RW'(seed[18:16]); opValid = 1'b1;
      accModel = refMac(accModel, opA, opB, int'(seed[18:16]), tag);
      @(negedge clk);
      opValid = 1'b0;
      check("R4", accModel);
    end

    // Sweep: every first operand, twelve second operands, two acc styles, every r
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 12; k++) begin
        logic [7:0] bv;
        bv = 8'(k * 21 + 5);
        for (int mode = 0; mode < 2; mode++) begin
          logic [11:0] accV;
          int pr, es;
          seed = nextRand(seed);
          accV = seed[11:0];
          if (mode == 1 && a[6:3] != 0 && bv[6:3] != 0) begin
            pr = (8 + a[2:0]) * (8 + int'(bv[2:0]));
            es = a[6:3] + int'(bv[6:3]) + ((pr >= 128) ? 2 : 1);
            if (es > 31) es = 31;
            accV = {~(a[7] ^ bv[7]), 5'(es),
                    6'((pr >= 128) ? (pr >> 1) : pr) ^ {4'b0, seed[13:12]}};
          end
          for (int r = 0; r < 8; r++) runCase(accV, 8'(a), bv, r, "");
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule